// File: doc/BRIEF.md
# Bus Clock Divider and Gating Unit

This unit takes one main clock and produces clock-enable pulses for a processor domain and three peripheral-bus domains. Each domain has its own power-of-two divider, selected by a 3-bit code. A domain's enable pulse is one main-clock cycle wide. It repeats every 2^code cycles. Everything is synchronous to the main clock, and downstream logic uses the pulses as clock enables, not as derived clocks.

Each peripheral bus has its own per-module gate mask. The high-speed bus also has a per-module gate mask, and it runs on the processor-domain pulse. A module whose mask bit is 0 gets no enable at all. Masks change only through set operations and clear operations. A set or clear touches the bits that are 1 in the write data and leaves every other bit as it was.

A single register-style write port carries every change. An operation code picks the target. A bus index picks which peripheral bus the operation applies to. A write that names a missing bus, or uses an unknown operation, changes nothing and raises an error status.

Top module: `busclk_unit`

## Requirements
- R1: After reset, every divider code is 0 and every mask bit is 1, so every domain enable and every module enable is high on every cycle.
- R2: A write with op 0 loads the processor divider code from data bits [2:0]. A write with op 1 loads the code for the bus given by the bus index (0, 1 or 2). Once active, code k gives a one-cycle enable pulse every 2^k main-clock cycles.
- R3: A domain running with code 0 asserts its enable on every cycle.
- R4: Op 2 (with a bus index) and op 4 (high-speed bus) are mask-set operations. Each data bit at 1 sets the matching mask bit, and each data bit at 0 leaves its mask bit unchanged.
- R5: Op 3 (with a bus index) and op 5 (high-speed bus) are mask-clear operations. Each data bit at 1 clears the matching mask bit, and each data bit at 0 leaves its mask bit unchanged.
- R6: A module enable is high only in a cycle where its domain's enable pulse is high and its mask bit is 1. The high-speed bus modules follow the processor domain.
- R7: A write with bus index 3 on ops 1 to 3, or any write with op 6 or 7, leaves every code and mask unchanged. The cycle after such a write, the error output is high for one cycle.
- R8: A new divider code takes effect only at the current terminal count of its domain. The period in progress completes at the old length, and the periods after it have the new length.
- R9: Writing one domain's code or one bus's mask has no effect on the other domains' enable pulses or on the other buses' masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one operation |
| wrOp | input | 3 | Operation code (0 to 5 valid) |
| wrBus | input | 2 | Peripheral bus index (0 to 2 valid) |
| wrData | input | DATA_W | Divider code in bits [2:0], or mask bits |
| wrErr | output | 1 | Invalid-argument status, one cycle after the write |
| cpuEn | output | 1 | Processor-domain enable pulse |
| busEn | output | 3 | Per-bus enable pulses |
| hsModEn | output | HS_MODS | Gated enables for high-speed bus modules |
| pbModEn | output | 3*PB_MODS | Gated enables for peripheral-bus modules, bus 0 in the low slice |

## Verification
The bench builds the unit with eight high-speed modules and six modules per peripheral bus. The two mask widths differ, so the mask writes must take their bits from the low end of the shared data word. It uses codes up to 7 on one bus, which brings the full 128-cycle period and its terminal count within reach. It changes codes in the middle of a period, so that a period completes at its old length before the new length starts.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int NUM_BUS = 3;
  localparam int CODE_W  = 3;
  localparam int BUS_W   = 2;
  localparam int NUM_DOM = NUM_BUS + 1;

  typedef enum logic [2:0] {
    OP_CPU_DIV = 3'd0,
    OP_BUS_DIV = 3'd1,
    OP_BUS_SET = 3'd2,
    OP_BUS_CLR = 3'd3,
    OP_HS_SET  = 3'd4,
    OP_HS_CLR  = 3'd5
  } wr_op_e;

  typedef struct packed {
    logic               cpuDivLd;
    logic [NUM_BUS-1:0] busDivLd;
    logic [NUM_BUS-1:0] busSet;
    logic [NUM_BUS-1:0] busClr;
    logic               hsSet;
    logic               hsClr;
  } strobe_t;
endpackage

// File: rtl/busclk_ctrl.sv
module busclk_ctrl
  import busclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrOp,
  input  logic [BUS_W-1:0] wrBus,
  output strobe_t          strobe,
  output logic             wrErr
);
  logic busOp;
  logic busOk;
  logic badWr;

  assign busOp = (wrOp == OP_BUS_DIV) || (wrOp == OP_BUS_SET) || (wrOp == OP_BUS_CLR);
  assign busOk = wrBus < BUS_W'(NUM_BUS);
  assign badWr = wrEn && ((busOp && !busOk) || (wrOp > OP_HS_CLR));

  always_comb begin
    strobe = '0;
    strobe.cpuDivLd = wrEn && (wrOp == OP_CPU_DIV);
    strobe.hsSet    = wrEn && (wrOp == OP_HS_SET);
    strobe.hsClr    = wrEn && (wrOp == OP_HS_CLR);
    for (int b = 0; b < NUM_BUS; b++) begin
      strobe.busDivLd[b] = wrEn && (wrOp == OP_BUS_DIV) && (wrBus == BUS_W'(b));
      strobe.busSet[b]   = wrEn && (wrOp == OP_BUS_SET) && (wrBus == BUS_W'(b));
      strobe.busClr[b]   = wrEn && (wrOp == OP_BUS_CLR) && (wrBus == BUS_W'(b));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= badWr;
  end

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe) && !(badWr && (strobe != '0)));
endmodule

// File: rtl/busclk_divider.sv
module busclk_divider #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [CODE_W-1:0] ldCode,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] curCode;
  logic [CODE_W-1:0] pendCode;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;

  assign lim  = CNT_W'((32'd1 << curCode) - 32'd1);
  assign tick = (cnt == lim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      curCode  <= '0;
      pendCode <= '0;
    end else begin
      if (tick) begin
        cnt     <= '0;
        curCode <= pendCode;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (ldEn) pendCode <= ldCode;
    end
  end

  assert_code_at_terminal_R8: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(curCode));
  assert_div1_every_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curCode == '0) |-> tick);
endmodule

// File: rtl/busclk_datapath.sv
module busclk_datapath
  import busclk_pkg::*;
#(
  parameter int HS_MODS = 8,
  parameter int PB_MODS = 8,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       cpuEn,
  output logic [NUM_BUS-1:0]         busEn,
  output logic [HS_MODS-1:0]         hsModEn,
  output logic [NUM_BUS*PB_MODS-1:0] pbModEn,
  output logic [HS_MODS-1:0]         hsMask,
  output logic [NUM_BUS*PB_MODS-1:0] pbMask
);
  logic [NUM_DOM-1:0] ldVec;
  logic [NUM_DOM-1:0] tickVec;
  logic [HS_MODS-1:0] hsData;
  logic [PB_MODS-1:0] pbData;

  assign ldVec  = {strobe.busDivLd, strobe.cpuDivLd};
  assign hsData = wrData[HS_MODS-1:0];
  assign pbData = wrData[PB_MODS-1:0];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    busclk_divider #(.CODE_W(CODE_W)) u_div (
      .clk    (clk),
      .rstN   (rstN),
      .ldEn   (ldVec[d]),
      .ldCode (wrData[CODE_W-1:0]),
      .tick   (tickVec[d])
    );
  end

  assign cpuEn = tickVec[0];
  assign busEn = tickVec[NUM_DOM-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             hsMask <= '1;
    else if (strobe.hsSet) hsMask <= hsMask | hsData;
    else if (strobe.hsClr) hsMask <= hsMask & ~hsData;
  end
  assign hsModEn = hsMask & {HS_MODS{cpuEn}};

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pbMask[b*PB_MODS +: PB_MODS] <= '1;
      else if (strobe.busSet[b]) pbMask[b*PB_MODS +: PB_MODS] <= pbMask[b*PB_MODS +: PB_MODS] | pbData;
      else if (strobe.busClr[b]) pbMask[b*PB_MODS +: PB_MODS] <= pbMask[b*PB_MODS +: PB_MODS] & ~pbData;
    end
    assign pbModEn[b*PB_MODS +: PB_MODS] = pbMask[b*PB_MODS +: PB_MODS] & {PB_MODS{busEn[b]}};

    assert_bus_set_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.busSet[b] |=> ((pbMask[b*PB_MODS +: PB_MODS] & $past(pbData)) == $past(pbData)));
    assert_bus_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.busClr[b] |=> ((pbMask[b*PB_MODS +: PB_MODS] & $past(pbData)) == '0));
  end

  assert_hs_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hsSet |=> ((hsMask & $past(hsData)) == $past(hsData)));
  assert_hs_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hsClr |=> ((hsMask & $past(hsData)) == '0));
endmodule

// File: rtl/busclk_unit.sv
module busclk_unit
  import busclk_pkg::*;
#(
  parameter int HS_MODS = 8,
  parameter int PB_MODS = 8,
  parameter int DATA_W  = (HS_MODS > PB_MODS) ? HS_MODS : PB_MODS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [2:0]                 wrOp,
  input  logic [1:0]                 wrBus,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       wrErr,
  output logic                       cpuEn,
  output logic [2:0]                 busEn,
  output logic [HS_MODS-1:0]         hsModEn,
  output logic [3*PB_MODS-1:0]       pbModEn
);
  strobe_t                    strobe;
  logic [HS_MODS-1:0]         hsMask;
  logic [NUM_BUS*PB_MODS-1:0] pbMask;

  busclk_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrOp   (wrOp),
    .wrBus  (wrBus),
    .strobe (strobe),
    .wrErr  (wrErr)
  );

  busclk_datapath #(
    .HS_MODS (HS_MODS),
    .PB_MODS (PB_MODS),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .cpuEn   (cpuEn),
    .busEn   (busEn),
    .hsModEn (hsModEn),
    .pbModEn (pbModEn),
    .hsMask  (hsMask),
    .pbMask  (pbMask)
  );

  assert_invalid_no_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> ((hsMask == $past(hsMask)) && (pbMask == $past(pbMask))));
endmodule

// File: tb/busclk_unit_test.sv
module busclk_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 8;
  localparam int PB = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrOp = '0;
  logic [1:0]    wrBus = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrErr;
  logic          cpuEn;
  logic [2:0]    busEn;
  logic [HS-1:0] hsModEn;
  logic [3*PB-1:0] pbModEn;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmpOn = 0;

  // behavioural reference: domain 0 = processor, 1..3 = buses
  int mCnt[4];
  int mCur[4];
  int mPend[4];
  int mHs;
  int mPb[3];
  bit mErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  busclk_unit #(.HS_MODS(HS), .PB_MODS(PB)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOp(wrOp), .wrBus(wrBus),
    .wrData(wrData), .wrErr(wrErr), .cpuEn(cpuEn), .busEn(busEn),
    .hsModEn(hsModEn), .pbModEn(pbModEn)
  );

  function automatic bit mTick(int d);
    return mCnt[d] == ((1 << mCur[d]) - 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 4; d++) begin
      mCnt[d] = 0; mCur[d] = 0; mPend[d] = 0;
    end
    mHs = (1 << HS) - 1;
    for (int b = 0; b < 3; b++) mPb[b] = (1 << PB) - 1;
    mErr = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      for (int d = 0; d < 4; d++) begin
        if (mTick(d)) begin
          mCnt[d] = 0;
          mCur[d] = mPend[d];
        end else mCnt[d]++;
      end
      mErr = 0;
      if (wrEn) begin
        case (wrOp)
          3'd0: mPend[0] = int'(wrData[2:0]);
          3'd1: if (wrBus < 3) mPend[wrBus + 1] = int'(wrData[2:0]); else mErr = 1;
          3'd2: if (wrBus < 3) mPb[wrBus] = mPb[wrBus] | int'(wrData[PB-1:0]); else mErr = 1;
          3'd3: if (wrBus < 3) mPb[wrBus] = mPb[wrBus] & ~int'(wrData[PB-1:0]); else mErr = 1;
          3'd4: mHs = mHs | int'(wrData[HS-1:0]);
          3'd5: mHs = mHs & ~int'(wrData[HS-1:0]);
          default: mErr = 1;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R2 R3 R8 R9 cpuEn", cpuEn, mTick(0));
      for (int b = 0; b < 3; b++) begin
        check("R2 R3 R8 R9 busEn", busEn[b], mTick(b + 1));
        check("R4 R5 R6 R7 R9 pbModEn", pbModEn[b*PB +: PB], mTick(b + 1) ? mPb[b] : 0);
      end
      check("R4 R5 R6 hsModEn", hsModEn, mTick(0) ? mHs : 0);
      check("R7 wrErr", wrErr, mErr);
    end
  end

  task automatic doWrite(input logic [2:0] op, input logic [1:0] bus, input logic [DW-1:0] data);
    wrEn = 1'b1; wrOp = op; wrBus = bus; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrOp = '0; wrBus = '0; wrData = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R1: all enables high right after reset
    check("R1 cpuEn", cpuEn, 1);
    check("R1 busEn", busEn, 3'b111);
    check("R1 hsModEn", hsModEn, (1 << HS) - 1);
    check("R1 pbModEn", pbModEn, (1 << (3*PB)) - 1);
    // R3: code 0 pulses every cycle
    begin
      int cnt = 0;
      for (int i = 0; i < 8; i++) begin
        if (cpuEn) cnt++;
        @(negedge clk);
      end
      check("R3 pulse count", cnt, 8);
    end
    // R2 R9: distinct codes per domain
    doWrite(3'd1, 2'd0, 8'd2);
    doWrite(3'd1, 2'd1, 8'd3);
    doWrite(3'd0, 2'd0, 8'd1);
    idle(40);
    // R8: change mid-period
    doWrite(3'd1, 2'd1, 8'd1);
    idle(3);
    doWrite(3'd1, 2'd0, 8'd4);
    idle(50);
    // R5 R4 on high-speed mask
    doWrite(3'd5, 2'd0, 8'h0F);
    idle(6);
    doWrite(3'd4, 2'd0, 8'h03);
    idle(6);
    // R5 R4 on bus 2 mask, upper data bits beyond PB
    doWrite(3'd3, 2'd2, 8'hEA);
    idle(6);
    doWrite(3'd2, 2'd2, 8'h02);
    idle(6);
    // R7: bad bus index and unknown ops
    doWrite(3'd3, 2'd3, 8'hFF);
    check("R7 err flag", wrErr, 1);
    doWrite(3'd1, 2'd3, 8'h05);
    doWrite(3'd6, 2'd0, 8'hFF);
    doWrite(3'd7, 2'd1, 8'hFF);
    doWrite(3'd2, 2'd3, 8'h00);
    idle(10);
    // R2 R8: longest period on bus 2, then back to fastest
    doWrite(3'd1, 2'd2, 8'd7);
    idle(300);
    doWrite(3'd1, 2'd2, 8'd0);
    doWrite(3'd0, 2'd0, 8'd5);
    idle(200);
    doWrite(3'd3, 2'd0, 8'h3F);
    idle(20);
    cmpOn = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule